// File: doc/BRIEF.md
# Chip reset sequencing controller

This block merges every reason for resetting the chip into one active-low system reset. Three sources feed it: an external reset pin that is active low, a single-cycle software reset strobe, and a flag from the supply monitor that is high while the supply is below its threshold. The pin first passes through a two-flop synchroniser. A low-level counter then rejects short glitches. A low level that lasts at least `MIN_LOW_CYCLES` clock cycles counts as a real request.

Reset stays asserted for as long as any source is still active. When the last one goes away, reset is held for another `RELEASE_CYCLES` cycles and then released. For the pin, this release sequence only begins once the synchronised level has returned high. A one-hot cause register records which source opened the latest reset episode. That reset does not clear the register, so software can read it once it is running again.

A power-on reset input (`por_ni`, asynchronous) clears the controller. Its release is synchronised to the clock.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_ni` is low, `sys_rst_no` is 0 and `cause_o` is 4'b0001 (power-on). After `por_ni` rises, reset stays asserted while `supply_low_i` is high. With the supply good and the pin high, `sys_rst_no` rises on the `RELEASE_CYCLES+3`-th clock edge after the `por_ni` release.
- R2: A low pulse on `ext_pin_i` that spans fewer than `MIN_LOW_CYCLES` rising clock edges never asserts reset and leaves `cause_o` unchanged.
- R3: A low pulse spanning at least `MIN_LOW_CYCLES` edges asserts reset. `sys_rst_no` falls on the `MIN_LOW_CYCLES+3`-th edge after the pin falls. Reset stays asserted while the pin remains low.
- R4: After a qualifying external reset, `sys_rst_no` rises on the `RELEASE_CYCLES+4`-th clock edge after the pin returns high.
- R5: A software strobe while out of reset asserts `sys_rst_no` low on the next clock edge. Reset is released on the `RELEASE_CYCLES+2`-th edge, counted from the edge that samples the strobe.
- R6: A software strobe sampled while the release count is running restarts that count. Reset is then released on the `RELEASE_CYCLES+1`-th edge, counted from the edge that samples the strobe.
- R7: `supply_low_i` high asserts reset by the next clock edge and holds it. Reset is released on the `RELEASE_CYCLES+1`-th edge after the flag is sampled low.
- R8: `cause_o` is one-hot with bit 0 = power-on, bit 1 = external pin, bit 2 = software, bit 3 = supply. If several sources start a reset in the same cycle, the priority is supply, then external, then software.
- R9: `cause_o` changes only on the edge that moves the block from running into reset. Sources that arrive during reset, and the release itself, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_pin_i | input | 1 | External reset pin level, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset strobe, one cycle |
| supply_low_i | input | 1 | Supply below monitor threshold |
| sys_rst_no | output | 1 | Chip-wide reset, active low |
| cause_o | output | 4 | One-hot cause of the latest reset episode |

## Verification
The checker watches several properties on every cycle:
- the cause code stays one-hot;
- the cause changes only on the way into reset;
- a software strobe or a low-supply flag always leaves reset asserted on the following cycle;
- reset never rises straight after a cycle in which either of those was present.

Other properties depend on counting cycles across a whole episode, and only the bench scenarios can show them. These are the glitch threshold of the pin filter, the exact release latency after each source, and the restart of the release count. The bench sweeps every pulse width around the threshold and measures each latency edge by edge.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int CAUSE_W = 4;

  // bit positions of the one-hot cause code
  localparam int CAUSE_POR    = 0;
  localparam int CAUSE_EXT    = 1;
  localparam int CAUSE_SW     = 2;
  localparam int CAUSE_SUPPLY = 3;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rst_por_sync.sv
module rst_por_sync (
  input  logic clk_i,
  input  logic por_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int MIN_LOW_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic ext_req_o
);

  localparam int CNT_W = $clog2(MIN_LOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_CYCLES);

  logic             sync1_q;
  logic             sync2_q;
  logic [CNT_W-1:0] low_cnt_q;
  logic [CNT_W-1:0] low_cnt_d;
  logic             cnt_en;

  // two-flop synchroniser, idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  // saturating low-level counter, cleared whenever the pin reads high
  always_comb begin
    cnt_en    = sync2_q || (low_cnt_q != CNT_MAX);
    low_cnt_d = low_cnt_q;
    if (sync2_q) begin
      low_cnt_d = '0;
    end else if (low_cnt_q != CNT_MAX) begin
      low_cnt_d = low_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
    end else if (cnt_en) begin
      low_cnt_q <= low_cnt_d;
    end
  end

  assign ext_req_o = (low_cnt_q == CNT_MAX);

endmodule

// File: rtl/rst_release_fsm.sv
module rst_release_fsm
  import rst_seq_pkg::*;
#(
  parameter int RELEASE_CYCLES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_req_i,
  input  logic               supply_low_i,
  input  logic               sw_req_i,
  output logic               sys_rst_no,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int REL_W = $clog2(RELEASE_CYCLES + 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RELEASE_CYCLES - 1);

  seq_state_e         state_q, state_d;
  logic [REL_W-1:0]   rel_cnt_q, rel_cnt_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               cause_en;
  logic               level_req;

  assign level_req = ext_req_i || supply_low_i;

  always_comb begin
    state_d   = state_q;
    rel_cnt_d = rel_cnt_q;
    cause_d   = cause_q;
    cause_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (level_req || sw_req_i) begin
          state_d  = ST_HOLD;
          cause_en = 1'b1;
          cause_d  = '0;
          if (supply_low_i)   cause_d[CAUSE_SUPPLY] = 1'b1;
          else if (ext_req_i) cause_d[CAUSE_EXT]    = 1'b1;
          else                cause_d[CAUSE_SW]     = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!level_req) begin
          state_d   = ST_COUNT;
          rel_cnt_d = '0;
        end
      end
      ST_COUNT: begin
        if (level_req) begin
          state_d = ST_HOLD;
        end else if (sw_req_i) begin
          rel_cnt_d = '0;
        end else if (rel_cnt_q == REL_LAST) begin
          state_d = ST_RUN;
        end else begin
          rel_cnt_d = rel_cnt_q + 1'b1;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HOLD;
      rel_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      rel_cnt_q <= rel_cnt_d;
    end
  end

  // the cause survives every reset except power-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_W'(1) << CAUSE_POR;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign sys_rst_no = (state_q == ST_RUN);
  assign cause_o    = cause_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int MIN_LOW_CYCLES = 16,
  parameter int RELEASE_CYCLES = 32
) (
  input  logic               clk_i,
  input  logic               por_ni,
  input  logic               ext_pin_i,
  input  logic               sw_rst_i,
  input  logic               supply_low_i,
  output logic               sys_rst_no,
  output logic [CAUSE_W-1:0] cause_o
);

  logic rst_n;
  logic ext_req;

  rst_por_sync u_por_sync (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .rst_no (rst_n)
  );

  rst_pin_filter #(
    .MIN_LOW_CYCLES (MIN_LOW_CYCLES)
  ) u_pin_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pin_i     (ext_pin_i),
    .ext_req_o (ext_req)
  );

  rst_release_fsm #(
    .RELEASE_CYCLES (RELEASE_CYCLES)
  ) u_release (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .ext_req_i    (ext_req),
    .supply_low_i (supply_low_i),
    .sw_req_i     (sw_rst_i),
    .sys_rst_no   (sys_rst_no),
    .cause_o      (cause_o)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk_i,
  input logic       por_ni,
  input logic       sw_rst_i,
  input logic       supply_low_i,
  input logic       sys_rst_no,
  input logic [3:0] cause_o
);

  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!por_ni)
    $countones(cause_o) == 1); // R8

  AST_CAUSE_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!por_ni)
    !$stable(cause_o) |-> $past(sys_rst_no)); // R9

  AST_SW_ASSERTS: assert property (@(posedge clk_i) disable iff (!por_ni)
    sw_rst_i |=> !sys_rst_no); // R5

  AST_SUPPLY_ASSERTS: assert property (@(posedge clk_i) disable iff (!por_ni)
    supply_low_i |=> !sys_rst_no); // R7

  AST_QUIET_RELEASE: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(sys_rst_no) |-> (!$past(supply_low_i) && !$past(sw_rst_i))); // R6

endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk_i        (clk_i),
  .por_ni       (por_ni),
  .sw_rst_i     (sw_rst_i),
  .supply_low_i (supply_low_i),
  .sys_rst_no   (sys_rst_no),
  .cause_o      (cause_o)
);

// File: tb/rst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;

  localparam int MINW = 4;
  localparam int REL  = 6;

  logic       clk = 1'b0;
  logic       por_n;
  logic       pin;
  logic       sw;
  logic       sup;
  logic       rst_n;
  logic [3:0] cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.MIN_LOW_CYCLES(MINW), .RELEASE_CYCLES(REL)) dut_i (
    .clk_i        (clk),
    .por_ni       (por_n),
    .ext_pin_i    (pin),
    .sw_rst_i     (sw),
    .supply_low_i (sup),
    .sys_rst_no   (rst_n),
    .cause_o      (cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts edges (the first one is the next edge) until reset is released
  task automatic edges_to_release(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      n++;
      if (rst_n) break;
    end
  endtask

  task automatic ext_pulse(input int len);
    int first_low;
    int last_low;
    logic [3:0] cause_before;
    first_low    = 0;
    last_low     = 0;
    cause_before = cause;
    @(negedge clk); pin = 1'b0;
    for (int i = 1; i <= len; i++) begin
      @(posedge clk); #1;
      if (!rst_n && first_low == 0) first_low = i;
    end
    @(negedge clk); pin = 1'b1;
    for (int j = 1; j <= 40; j++) begin
      @(posedge clk); #1;
      if (!rst_n) begin
        if (first_low == 0) first_low = len + j;
        last_low = j;
      end
    end
    if (len < MINW) begin
      chk(first_low == 0, "R2 glitch ignored", first_low, 0);
      chk(cause == cause_before, "R2 cause kept", cause, cause_before);
    end else begin
      chk(first_low == MINW + 3, "R3 assert latency", first_low, MINW + 3);
      chk(last_low + 1 == REL + 4, "R4 release latency", last_low + 1, REL + 4);
      chk(cause == 4'b0010, "R8 external cause", cause, 4'b0010);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    por_n = 1'b0; pin = 1'b1; sw = 1'b0; sup = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(rst_n == 1'b0, "R1 reset during por", rst_n, 0);
    chk(cause == 4'b0001, "R1 power-on cause", cause, 1);

    // power-up held by low supply
    @(negedge clk); por_n = 1'b1;
    repeat (12) @(posedge clk);
    #1;
    chk(rst_n == 1'b0, "R1 held by supply", rst_n, 0);
    @(negedge clk); sup = 1'b0;
    edges_to_release(n);
    chk(n == REL + 1, "R1 release after supply ok", n, REL + 1);
    chk(cause == 4'b0001, "R9 cause after power-up", cause, 1);

    // power-up with good supply
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    edges_to_release(n);
    chk(n == REL + 3, "R1 por release latency", n, REL + 3);

    // sweep pulse widths around the threshold
    for (int len = 1; len <= MINW + 4; len++) begin
      ext_pulse(len);
    end

    // software reset
    @(negedge clk); sw = 1'b1;
    @(posedge clk); #1;
    chk(rst_n == 1'b0, "R5 sw asserts", rst_n, 0);
    chk(cause == 4'b0100, "R8 software cause", cause, 4'b0100);
    @(negedge clk); sw = 1'b0;
    n = 1;
    for (int i = 0; i < 200 && !rst_n; i++) begin
      @(posedge clk); #1; n++;
    end
    chk(n == REL + 2, "R5 sw release latency", n, REL + 2);

    // software strobe during release count restarts it
    @(negedge clk); sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    @(negedge clk);
    @(negedge clk); sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    n = 1;
    for (int i = 0; i < 200 && !rst_n; i++) begin
      @(posedge clk); #1; n++;
    end
    chk(n == REL + 1, "R6 restart latency", n, REL + 1);

    // short glitch leaves software cause in place
    ext_pulse(MINW - 1);
    chk(cause == 4'b0100, "R9 cause sticky", cause, 4'b0100);

    // supply and software together: supply wins
    @(negedge clk); sup = 1'b1; sw = 1'b1;
    @(posedge clk); #1;
    chk(cause == 4'b1000, "R8 priority supply", cause, 4'b1000);
    @(negedge clk); sw = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    chk(rst_n == 1'b0, "R7 held while supply low", rst_n, 0);
    @(negedge clk); sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    chk(cause == 4'b1000, "R9 sw in reset ignored", cause, 4'b1000);
    @(negedge clk); sup = 1'b0;
    edges_to_release(n);
    chk(n == REL + 1, "R7 supply release latency", n, REL + 1);

    // supply alone from running
    @(negedge clk); sup = 1'b1;
    @(posedge clk); #1;
    chk(rst_n == 1'b0, "R7 supply asserts", rst_n, 0);
    @(negedge clk); sup = 1'b0;
    edges_to_release(n);
    chk(n == REL + 1, "R7 release again", n, REL + 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule